// File: doc/BRIEF.md
# SHA Padding Block Buffer

This block sits between a byte-wide message source and a SHA-1/SHA-256 compression core. Bytes arrive one per handshake and are gathered into a 64-byte buffer; each time the buffer fills, the whole 512-bit block is offered to the core over a valid/ready interface. While the buffer is still filling, nothing reaches the core.

When the source flags the final byte, the block builds the closing blocks itself. It appends the 0x80 marker and zero fill. It then writes the message bit length, which is eight times the bytes counted since the message began, big-endian into the last 32-bit word. This produces one or two final blocks, depending on how full the buffer was. The first block of every message carries a strobe that tells the core to load its initial hash state. A one-cycle done pulse follows acceptance of the last block. The digest length that matches the selected algorithm is presented to the readout logic.

Top module: `sha_pad_buffer`

## Requirements
- R1: Blocks are 64 bytes. Message byte k of a block sits at bits [511-8k -: 8] of `blk_data_o`, so the first byte is the most significant and 32-bit word 0 occupies bits [511:480]. A non-final block is emitted only once all 64 of its bytes have been accepted, and it contains exactly those bytes in order.
- R2: While fewer than 64 bytes are buffered and no last byte has been accepted, `blk_valid_o` stays low.
- R3: In the closing block, the byte directly after the last buffered message byte is 0x80. Every byte after the marker is zero, except the length word.
- R4: If 0 to 55 bytes remain buffered at finish, exactly one closing block is emitted. It holds the data, the marker, zeros and the length.
- R5: If 56 to 63 bytes remain buffered at finish, two blocks follow. The first holds data, the marker and zeros, with no length. The second is all zero apart from the length word.
- R6: If the last byte completes a full 64-byte buffer, that block is sent unchanged. It is followed by a block whose byte 0 is 0x80 and whose last word is the length.
- R7: The length field is 8 × (bytes in the message), as an unsigned 32-bit value in bits [31:0] of the final block. Bits [63:32] are zero.
- R8: `blk_first_o` is high with the first block of each message, including when that block is a closing block, and low with every other block. It is never high without `blk_valid_o`.
- R9: `digest_len_o` is 20 when `alg_i` was 0 and 32 when `alg_i` was 1, sampled with the first byte of a message. After reset it is 32.
- R10: While `blk_valid_o` is high and `blk_ready_i` low, the block data and the first strobe stay stable and `in_ready_o` is low. `in_ready_o` and `blk_valid_o` are never high together.
- R11: A synchronous `init_i` discards buffered bytes, zeroes the byte count and re-arms the first-block strobe.
- R12: `done_o` pulses for exactly one cycle, in the cycle after the last block of a message is accepted. The next message then starts with a zero count and the first strobe armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Synchronous restart of the message state |
| alg_i | input | 1 | Algorithm select: 0 SHA-1, 1 SHA-256 |
| in_valid_i | input | 1 | Input byte valid |
| in_data_i | input | 8 | Input byte |
| in_last_i | input | 1 | Marks the final byte of the message |
| in_ready_o | output | 1 | Block can accept a byte |
| blk_valid_o | output | 1 | Block offered to the core |
| blk_data_o | output | 512 | Block payload, byte 0 in the top bits |
| blk_first_o | output | 1 | First block of a message |
| blk_ready_i | input | 1 | Core accepts the block |
| done_o | output | 1 | One-cycle pulse after the last block is accepted |
| digest_len_o | output | 6 | Digest size in bytes for the selected algorithm |

## Verification
The bench targets the padding boundaries with message lengths of 1, 55, 56, 63, 64, 65 and 128 bytes. A design that uses the wrong limit would drop the length into a block that lacks room for it, or add a spurious extra block. A design that treats the full-buffer finish like the partial case would overwrite data byte 0 with the marker. Random core back-pressure is applied so that a design that accepts bytes while a block is stalled would corrupt or lose data. An init issued after a partial message is used to expose stale fill or length state. Back-to-back messages show whether the first-block strobe re-arms, and whether it fires on a closing block when no full block was ever sent.

// File: rtl/sha_pad_pkg.sv
package sha_pad_pkg;
  typedef enum logic [1:0] {
    ST_FILL  = 2'd0,
    ST_SEND  = 2'd1,
    ST_PAD1  = 2'd2,
    ST_PAD2  = 2'd3
  } pad_st_e;

  localparam logic [5:0] DLEN_SHA1   = 6'd20;
  localparam logic [5:0] DLEN_SHA256 = 6'd32;

  function automatic logic [5:0] digest_len(input logic sha256);
    return sha256 ? DLEN_SHA256 : DLEN_SHA1;
  endfunction
endpackage

// File: rtl/sha_pad_byte_buf.sv
module sha_pad_byte_buf #(
  parameter int BLK_BYTES = 64,
  localparam int FILL_W   = $clog2(BLK_BYTES + 1),
  localparam int IDX_W    = $clog2(BLK_BYTES),
  localparam int BLK_W    = 8 * BLK_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [7:0]        byte_i,
  input  logic              clr_i,
  output logic [FILL_W-1:0] fill_o,
  output logic [BLK_W-1:0]  data_o
);
  logic [7:0]        bytes_q [BLK_BYTES];
  logic [FILL_W-1:0] fill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q <= '0;
      for (int i = 0; i < BLK_BYTES; i++) bytes_q[i] <= '0;
    end else if (clr_i) begin
      fill_q <= '0;
    end else if (wr_i) begin
      bytes_q[fill_q[IDX_W-1:0]] <= byte_i;
      fill_q <= fill_q + 1'b1;
    end
  end

  for (genvar i = 0; i < BLK_BYTES; i++) begin : g_pack
    assign data_o[8*(BLK_BYTES-1-i) +: 8] = bytes_q[i];
  end

  assign fill_o = fill_q;
endmodule

// File: rtl/sha_pad_format.sv
module sha_pad_format #(
  parameter int BLK_BYTES       = 64,
  parameter int LEN_W           = 32,
  parameter int LEN_FIELD_BYTES = 8,
  localparam int FILL_W   = $clog2(BLK_BYTES + 1),
  localparam int BLK_W    = 8 * BLK_BYTES,
  localparam int LEN_B    = LEN_W / 8,
  localparam int ONE_LIM  = BLK_BYTES - LEN_FIELD_BYTES - 1
) (
  input  logic [BLK_W-1:0]  buf_i,
  input  logic [FILL_W-1:0] fill_i,
  input  logic [LEN_W-1:0]  bit_len_i,
  input  logic              second_i,
  output logic              two_blk_o,
  output logic [BLK_W-1:0]  pad_o
);
  assign two_blk_o = fill_i > FILL_W'(ONE_LIM);

  for (genvar i = 0; i < BLK_BYTES; i++) begin : g_byte
    localparam int TAIL = i - (BLK_BYTES - LEN_B);
    logic [7:0] len_b;
    logic [7:0] b;
    if (TAIL >= 0) begin : g_len
      assign len_b = bit_len_i[8*(LEN_B-1-TAIL) +: 8];
    end else begin : g_nolen
      assign len_b = '0;
    end
    always_comb begin
      if (second_i)                    b = len_b;
      else if (FILL_W'(i) < fill_i)    b = buf_i[8*(BLK_BYTES-1-i) +: 8];
      else if (FILL_W'(i) == fill_i)   b = 8'h80;
      else if (!two_blk_o)             b = len_b;
      else                             b = '0;
    end
    assign pad_o[8*(BLK_BYTES-1-i) +: 8] = b;
  end
endmodule

// File: rtl/sha_pad_ctrl.sv
module sha_pad_ctrl
  import sha_pad_pkg::*;
#(
  parameter int BLK_BYTES = 64,
  parameter int LEN_W     = 32,
  localparam int FILL_W   = $clog2(BLK_BYTES + 1),
  localparam int CNT_W    = LEN_W - 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              alg_i,
  input  logic              in_valid_i,
  input  logic              in_last_i,
  input  logic              blk_ready_i,
  input  logic [FILL_W-1:0] fill_i,
  input  logic              two_blk_i,
  output logic              in_ready_o,
  output logic              blk_valid_o,
  output logic              blk_first_o,
  output logic              send_raw_o,
  output logic              pad_second_o,
  output logic              buf_wr_o,
  output logic              buf_clr_o,
  output logic [LEN_W-1:0]  bit_len_o,
  output logic              alg_o,
  output logic              done_o
);
  pad_st_e          st_q, st_d;
  logic             first_q, last_pend_q, alg_q, done_q;
  logic [CNT_W-1:0] cnt_q;
  logic             acc, hs, fill_last, finish;

  assign in_ready_o   = (st_q == ST_FILL);
  assign blk_valid_o  = (st_q != ST_FILL);
  assign blk_first_o  = blk_valid_o & first_q;
  assign send_raw_o   = (st_q == ST_SEND);
  assign pad_second_o = (st_q == ST_PAD2);
  assign acc          = in_valid_i & in_ready_o & ~init_i;
  assign hs           = blk_valid_o & blk_ready_i;
  assign fill_last    = (fill_i == FILL_W'(BLK_BYTES - 1));
  assign finish       = hs & ((st_q == ST_PAD2) | ((st_q == ST_PAD1) & ~two_blk_i));
  assign buf_wr_o     = acc;
  assign buf_clr_o    = init_i | (hs & (st_q != ST_PAD2));
  assign bit_len_o    = {cnt_q, 3'b000};
  assign alg_o        = alg_q;
  assign done_o       = done_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_FILL: if (acc) begin
        if (fill_last)      st_d = ST_SEND;
        else if (in_last_i) st_d = ST_PAD1;
      end
      ST_SEND: if (hs) st_d = last_pend_q ? ST_PAD1 : ST_FILL;
      ST_PAD1: if (hs) st_d = two_blk_i ? ST_PAD2 : ST_FILL;
      ST_PAD2: if (hs) st_d = ST_FILL;
      default: st_d = ST_FILL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_FILL;
      first_q     <= 1'b1;
      last_pend_q <= 1'b0;
      alg_q       <= 1'b1;
      done_q      <= 1'b0;
      cnt_q       <= '0;
    end else if (init_i) begin
      st_q        <= ST_FILL;
      first_q     <= 1'b1;
      last_pend_q <= 1'b0;
      done_q      <= 1'b0;
      cnt_q       <= '0;
    end else begin
      st_q   <= st_d;
      done_q <= finish;
      if (acc) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == '0) alg_q <= alg_i;
        if (fill_last) last_pend_q <= in_last_i;
      end
      if (finish) begin
        cnt_q       <= '0;
        first_q     <= 1'b1;
        last_pend_q <= 1'b0;
      end else if (hs) begin
        first_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sha_pad_buffer.sv
module sha_pad_buffer
  import sha_pad_pkg::*;
#(
  parameter int BLK_BYTES       = 64,
  parameter int LEN_W           = 32,
  parameter int LEN_FIELD_BYTES = 8,
  localparam int BLK_W  = 8 * BLK_BYTES,
  localparam int FILL_W = $clog2(BLK_BYTES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic             alg_i,
  input  logic             in_valid_i,
  input  logic [7:0]       in_data_i,
  input  logic             in_last_i,
  output logic             in_ready_o,
  output logic             blk_valid_o,
  output logic [BLK_W-1:0] blk_data_o,
  output logic             blk_first_o,
  input  logic             blk_ready_i,
  output logic             done_o,
  output logic [5:0]       digest_len_o
);
  logic [FILL_W-1:0] fill;
  logic [BLK_W-1:0]  buf_data, pad_data;
  logic [LEN_W-1:0]  bit_len;
  logic              buf_wr, buf_clr, two_blk, send_raw, pad_second, alg;

  sha_pad_byte_buf #(.BLK_BYTES(BLK_BYTES)) u_buf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (buf_wr),
    .byte_i (in_data_i),
    .clr_i  (buf_clr),
    .fill_o (fill),
    .data_o (buf_data)
  );

  sha_pad_format #(
    .BLK_BYTES(BLK_BYTES), .LEN_W(LEN_W), .LEN_FIELD_BYTES(LEN_FIELD_BYTES)
  ) u_fmt (
    .buf_i     (buf_data),
    .fill_i    (fill),
    .bit_len_i (bit_len),
    .second_i  (pad_second),
    .two_blk_o (two_blk),
    .pad_o     (pad_data)
  );

  sha_pad_ctrl #(.BLK_BYTES(BLK_BYTES), .LEN_W(LEN_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .init_i       (init_i),
    .alg_i        (alg_i),
    .in_valid_i   (in_valid_i),
    .in_last_i    (in_last_i),
    .blk_ready_i  (blk_ready_i),
    .fill_i       (fill),
    .two_blk_i    (two_blk),
    .in_ready_o   (in_ready_o),
    .blk_valid_o  (blk_valid_o),
    .blk_first_o  (blk_first_o),
    .send_raw_o   (send_raw),
    .pad_second_o (pad_second),
    .buf_wr_o     (buf_wr),
    .buf_clr_o    (buf_clr),
    .bit_len_o    (bit_len),
    .alg_o        (alg),
    .done_o       (done_o)
  );

  assign blk_data_o   = send_raw ? buf_data : pad_data;
  assign digest_len_o = digest_len(alg);
endmodule

// File: rtl/sha_pad_buffer_chk.sv
module sha_pad_buffer_chk #(
  parameter int BLK_W = 512
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             init_i,
  input logic             in_ready_o,
  input logic             blk_valid_o,
  input logic [BLK_W-1:0] blk_data_o,
  input logic             blk_first_o,
  input logic             blk_ready_i,
  input logic             done_o,
  input logic [5:0]       digest_len_o
);
  // R10: stalled block must hold
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_valid_o && !blk_ready_i && !init_i |=>
      blk_valid_o && $stable(blk_data_o) && $stable(blk_first_o));

  a_r10_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_ready_o && blk_valid_o));

  a_r12_done_after_hs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(blk_valid_o && blk_ready_i));

  a_r12_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_first_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_first_o |-> blk_valid_o);

  a_r9_dlen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    digest_len_o == 6'd20 || digest_len_o == 6'd32);
endmodule

bind sha_pad_buffer sha_pad_buffer_chk #(.BLK_W(BLK_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .init_i       (init_i),
  .in_ready_o   (in_ready_o),
  .blk_valid_o  (blk_valid_o),
  .blk_data_o   (blk_data_o),
  .blk_first_o  (blk_first_o),
  .blk_ready_i  (blk_ready_i),
  .done_o       (done_o),
  .digest_len_o (digest_len_o)
);

// File: tb/sha_pad_buffer_tb.sv
module sha_pad_buffer_tb;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         init_i = 1'b0;
  logic         alg_i = 1'b1;
  logic         in_valid_i = 1'b0;
  logic [7:0]   in_data_i = '0;
  logic         in_last_i = 1'b0;
  logic         in_ready_o, blk_valid_o, blk_first_o, done_o;
  logic [511:0] blk_data_o;
  logic         blk_ready_i = 1'b1;
  logic [5:0]   digest_len_o;

  int tests = 0, fails = 0, cyc = 0;
  logic [511:0] qd[$];
  logic         qf[$];
  string        qt[$];
  logic [15:0]  lfsr = 16'hACE1;
  logic         rnd_ready = 1'b0;

  always #4 clk = ~clk;

  sha_pad_buffer u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .init_i(init_i), .alg_i(alg_i),
    .in_valid_i(in_valid_i), .in_data_i(in_data_i), .in_last_i(in_last_i),
    .in_ready_o(in_ready_o), .blk_valid_o(blk_valid_o), .blk_data_o(blk_data_o),
    .blk_first_o(blk_first_o), .blk_ready_i(blk_ready_i), .done_o(done_o),
    .digest_len_o(digest_len_o)
  );

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  task automatic check(input logic ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    blk_ready_i <= rnd_ready ? lfsr[3] : 1'b1;
    if (cyc > 150000) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_ni && blk_valid_o) begin
      // R10: input side closed while a block is offered
      check(!in_ready_o, "R10 in_ready low while block pending", 64'(in_ready_o), 64'd0);
      if (blk_ready_i) begin
        if (qd.size() == 0) begin
          check(1'b0, "R2 unexpected block", 64'(blk_data_o[63:0]), 64'd0);
        end else begin
          logic [511:0] ed; logic ef; string et;
          ed = qd.pop_front(); ef = qf.pop_front(); et = qt.pop_front();
          tests++;
          if (blk_data_o !== ed) begin
            fails++;
            $display("FAIL %s block act=%h exp=%h", et, blk_data_o, ed);
          end
          check(blk_first_o == ef, {"R8 first strobe ", et}, 64'(blk_first_o), 64'(ef));
        end
      end
    end
  end

  function automatic logic [7:0] mbyte(input int seed, input int i);
    return 8'((seed * 7 + i * 13 + (i >> 3)) & 255);
  endfunction

  task automatic push_blk(input logic [511:0] d, input string t);
    qd.push_back(d); qf.push_back(qd.size() == 1 && qt.size() == 0 ? 1'b1 : 1'b0); qt.push_back(t);
  endtask

  task automatic put_byte(input logic [7:0] b, input logic l);
    in_valid_i = 1'b1; in_data_i = b; in_last_i = l;
    while (!in_ready_o) @(negedge clk);
    @(negedge clk);
    in_valid_i = 1'b0; in_last_i = 1'b0;
  endtask

  task automatic run_msg(input int n, input logic alg, input int seed, input bit probe, input string tx);
    int nfull, rem;
    logic [31:0] blen;
    logic [511:0] blk;
    nfull = n / 64; rem = n % 64; blen = 32'(n * 8);
    // build expected blocks (R1, R3..R7)
    for (int b = 0; b < nfull; b++) begin
      blk = '0;
      for (int k = 0; k < 64; k++) blk[511-8*k -: 8] = mbyte(seed, b*64 + k);
      push_blk(blk, {"R1 ", tx});
    end
    blk = '0;
    for (int k = 0; k < rem; k++) blk[511-8*k -: 8] = mbyte(seed, nfull*64 + k);
    blk[511-8*rem -: 8] = 8'h80;
    if (rem <= 55) begin
      blk[31:0] = blen;
      push_blk(blk, rem == 0 ? {"R6 R7 ", tx} : {"R3 R4 R7 ", tx});
    end else begin
      push_blk(blk, {"R3 R5 ", tx});
      blk = '0; blk[31:0] = blen;
      push_blk(blk, {"R5 R7 ", tx});
    end
    alg_i = alg;
    for (int i = 0; i < n; i++) begin
      if (probe && i == n - 1) begin
        repeat (4) begin
          @(negedge clk);
          check(!blk_valid_o, "R2 held while under a block", 64'(blk_valid_o), 64'd0);
        end
      end
      put_byte(mbyte(seed, i), i == n - 1);
    end
    begin
      int w = 0;
      while (!done_o && w < 5000) begin @(negedge clk); w++; end
    end
    check(done_o, {"R12 done pulse ", tx}, 64'(done_o), 64'd1);
    check(qd.size() == 0, {"R12 all blocks out before done ", tx}, 64'(qd.size()), 64'd0);
    check(digest_len_o == (alg ? 6'd32 : 6'd20), "R9 digest length", 64'(digest_len_o), alg ? 64'd32 : 64'd20);
    @(negedge clk);
    check(!done_o, "R12 done one cycle", 64'(done_o), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(in_ready_o, "R10 reset in_ready", 64'(in_ready_o), 64'd1);
    check(!blk_valid_o, "R2 reset no block", 64'(blk_valid_o), 64'd0);
    check(!done_o, "R12 reset done low", 64'(done_o), 64'd0);
    check(digest_len_o == 6'd32, "R9 reset digest length", 64'(digest_len_o), 64'd32);

    run_msg(1,   1'b1, 3, 1'b0, "len1");
    run_msg(55,  1'b0, 5, 1'b1, "len55");
    run_msg(56,  1'b1, 9, 1'b1, "len56");
    run_msg(63,  1'b0, 11, 1'b0, "len63");
    run_msg(64,  1'b1, 2, 1'b0, "len64");
    rnd_ready = 1'b1; // R10 back-pressure from here on
    run_msg(65,  1'b1, 17, 1'b0, "len65 bp");
    run_msg(128, 1'b0, 21, 1'b0, "len128 bp");
    run_msg(120, 1'b1, 23, 1'b0, "len120 bp");
    run_msg(200, 1'b0, 29, 1'b0, "len200 bp");

    // R11: partial message abandoned by init
    for (int i = 0; i < 10; i++) put_byte(8'hEE, 1'b0);
    init_i = 1'b1; @(negedge clk); init_i = 1'b0;
    check(in_ready_o && !blk_valid_o, "R11 idle after init", 64'(blk_valid_o), 64'd0);
    run_msg(3, 1'b1, 31, 1'b0, "R11 after init");
    run_msg(70, 1'b1, 37, 1'b0, "R11 next msg");
    summary();
  end
endmodule